// File: doc/BRIEF.md
# Cell Bus Frame Receive Checker

This block sits on the receive side of a device attached to a shared 32-bit cell bus. On that bus a frame lasts 16 clock cycles. Cycle 0 carries transmit requests, cycles 1 to 14 carry one cell of 56 bytes, and cycle 15 carries a grant word. The block captures the 14 cell words. While they arrive it folds a bit-interleaved parity byte over the checked span. In the grant cycle it compares that byte with the parity byte that the sender placed in the grant word. In the same cycle it checks the grant word's own parity and decides whether this device owns the bus in the next frame.

A `frame_start` pulse marks cycle 0 and realigns the internal sequencer. Without the pulse the sequencer runs on freely from frame to frame. The captured cell and the three result flags are published together at the clock edge that ends the grant cycle. They then hold for a whole frame.

The sequencer has four states. ST_IDLE is the state after reset, before any alignment. ST_REQ is cycle 0 in free-running mode. ST_CELL covers cycles 1 to 14. ST_GRANT is cycle 15. The transitions are:
- T_START: `frame_start` from any state to ST_CELL.
- T_IDLE_HOLD: ST_IDLE stays in ST_IDLE.
- T_REQ_CELL: ST_REQ to ST_CELL.
- T_CELL_NEXT: ST_CELL to ST_CELL on words 1 to 13.
- T_CELL_GRANT: ST_CELL to ST_GRANT after word 14.
- T_GRANT_REQ: ST_GRANT to ST_REQ.

Top module: `cbus_rx_check`

## Requirements
- R1: When `frame_start` is 1 in a cycle, that cycle is cycle 0. The next 14 cycles are cell words 1 to 14, and the cycle after them is the grant cycle.
- R2: After the grant cycle, `cell_data` holds the 14 cell words. Word 1 is in bits [447:416] and word 14 is in bits [31:0]. The value holds until the next grant cycle ends.
- R3: The parity byte starts at 8'hFF and is XORed with every checked byte. Each word is taken big-endian, with byte 0 in bits [31:24]. The checked bytes are bits [15:8] and [7:0] of word 1 and all four bytes of words 2 to 14, 54 bytes in total. `bip_err` is 1 exactly when the result differs from bits [31:24] of the grant word.
- R4: Bits [31:16] of word 1 (the routing header) have no effect on `bip_err`.
- R5: `gnt_par_err` is 1 exactly when bits [6:0] of the grant word contain an even number of ones.
- R6: `granted_next` is 1 exactly when bit 5 of the grant word is 1, the grant parity is correct and bits [4:0] equal `unit_addr`.
- R7: The three flags change only at the clock edge that ends a grant cycle. At all other times they hold their values.
- R8: A `frame_start` in the middle of a frame abandons that frame. Its grant never updates the outputs, and the flags reflect the restarted frame.
- R9: If the cycle after a grant cycle has `frame_start` at 0, that cycle is treated as cycle 0 and a new frame follows.
- R10: Reset clears all outputs. Until the first `frame_start`, no bus word updates them.
- R11: When bit 5 of the grant word is 0, `granted_next` is 0 even if the address matches and the parity is correct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Marks cycle 0 of a frame |
| bus_data | input | 32 | Cell bus data word |
| unit_addr | input | 5 | This device's unit address |
| cell_data | output | 448 | Captured cell, word 1 in the top bits |
| bip_err | output | 1 | Parity byte mismatch in the last frame |
| gnt_par_err | output | 1 | Grant word parity error in the last frame |
| granted_next | output | 1 | This device sends in the next frame |

## Verification
The parity-byte comparison and the grant-word checks are both decided from the same cycle-15 word, at the same clock edge. The bench builds frames in which a corrupted payload and an even-parity grant occur together. It also builds frames in which only one of the two is wrong, and frames in which a valid grant names this device while the parity byte is wrong. Each flag is judged on its own against the value the bench computes from the words it sent. A matching grant must not be masked by a parity-byte error, and the reverse must not happen either.

// File: rtl/cbus_rx_pkg.sv
package cbus_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_CELL  = 2'd2,
        ST_GRANT = 2'd3
    } rx_state_e;
endpackage

// File: rtl/cbus_frame_seq.sv
module cbus_frame_seq
    import cbus_rx_pkg::*;
#(
    parameter int WORDS = 14,
    parameter int IW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    output logic          in_cell,
    output logic          in_first,
    output logic          in_grant,
    output logic [IW-1:0] widx,
    output rx_state_e     state
);
    localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

    rx_state_e     st_q, st_d;
    logic [IW-1:0] idx_q, idx_d;

    // next state
    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        if (frame_start) begin
            st_d  = ST_CELL;          // T_START
            idx_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_IDLE;                // T_IDLE_HOLD
                ST_REQ: begin
                    st_d  = ST_CELL;                     // T_REQ_CELL
                    idx_d = '0;
                end
                ST_CELL: begin
                    if (idx_q == LAST) st_d = ST_GRANT;  // T_CELL_GRANT
                    else idx_d = idx_q + 1'b1;           // T_CELL_NEXT
                end
                ST_GRANT: st_d = ST_REQ;                 // T_GRANT_REQ
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    // outputs: a start pulse always means the word on the bus is cycle 0
    always_comb begin
        in_cell  = (st_q == ST_CELL) && !frame_start;
        in_grant = (st_q == ST_GRANT) && !frame_start;
        in_first = in_cell && (idx_q == '0);
        widx     = idx_q;
        state    = st_q;
    end
endmodule

// File: rtl/cbus_bip_acc.sv
module cbus_bip_acc #(
    parameter int DW   = 32,
    parameter int SKIP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_cell,
    input  logic          in_first,
    input  logic [DW-1:0] word,
    output logic [7:0]    acc
);
    localparam int BPW = DW / 8;

    logic [7:0] fold;
    logic [7:0] acc_q;

    always_comb begin
        fold = '0;
        for (int j = 0; j < BPW; j++) begin
            if (!(in_first && (j < SKIP)))
                fold = fold ^ word[DW-1-8*j -: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= 8'hFF;
        else if (in_cell)
            acc_q <= (in_first ? 8'hFF : acc_q) ^ fold;
    end

    assign acc = acc_q;
endmodule

// File: rtl/cbus_grant_chk.sv
module cbus_grant_chk #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_grant,
    input  logic [DW-1:0] word,
    input  logic [7:0]    acc,
    input  logic [AW-1:0] unit_addr,
    output logic          bip_err,
    output logic          par_err,
    output logic          granted
);
    localparam int EN_BIT  = AW;
    localparam int PAR_BIT = AW + 1;

    logic odd_ok, hit;

    always_comb begin
        odd_ok = ^word[PAR_BIT:0];
        hit    = word[EN_BIT] && odd_ok && (word[AW-1:0] == unit_addr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bip_err <= 1'b0;
            par_err <= 1'b0;
            granted <= 1'b0;
        end else if (in_grant) begin
            bip_err <= (acc != word[DW-1 -: 8]);
            par_err <= !odd_ok;
            granted <= hit;
        end
    end
endmodule

// File: rtl/cbus_cell_store.sv
module cbus_cell_store #(
    parameter int DW    = 32,
    parameter int WORDS = 14,
    parameter int IW    = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_cell,
    input  logic                in_grant,
    input  logic [IW-1:0]       widx,
    input  logic [DW-1:0]       word,
    output logic [WORDS*DW-1:0] cell_data
);
    logic [DW-1:0] shadow [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow[g] <= '0;
                cell_data[(WORDS-1-g)*DW +: DW] <= '0;
            end else begin
                if (in_cell && (widx == IW'(g)))
                    shadow[g] <= word;
                if (in_grant)
                    cell_data[(WORDS-1-g)*DW +: DW] <= shadow[g];
            end
        end
    end
endmodule

// File: rtl/cbus_rx_check.sv
module cbus_rx_check
    import cbus_rx_pkg::*;
#(
    parameter int DW    = 32,
    parameter int WORDS = 14,
    parameter int AW    = 5,
    parameter int SKIP  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic [DW-1:0]       bus_data,
    input  logic [AW-1:0]       unit_addr,
    output logic [WORDS*DW-1:0] cell_data,
    output logic                bip_err,
    output logic                gnt_par_err,
    output logic                granted_next
);
    localparam int IW = $clog2(WORDS);

    logic          in_cell, in_first, in_grant;
    logic [IW-1:0] widx;
    logic [7:0]    acc;
    rx_state_e     state;

    cbus_frame_seq #(.WORDS(WORDS), .IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .in_cell(in_cell), .in_first(in_first), .in_grant(in_grant),
        .widx(widx), .state(state)
    );

    cbus_bip_acc #(.DW(DW), .SKIP(SKIP)) u_bip (
        .clk(clk), .rst_n(rst_n), .in_cell(in_cell), .in_first(in_first),
        .word(bus_data), .acc(acc)
    );

    cbus_grant_chk #(.DW(DW), .AW(AW)) u_gnt (
        .clk(clk), .rst_n(rst_n), .in_grant(in_grant), .word(bus_data),
        .acc(acc), .unit_addr(unit_addr), .bip_err(bip_err),
        .par_err(gnt_par_err), .granted(granted_next)
    );

    cbus_cell_store #(.DW(DW), .WORDS(WORDS), .IW(IW)) u_store (
        .clk(clk), .rst_n(rst_n), .in_cell(in_cell), .in_grant(in_grant),
        .widx(widx), .word(bus_data), .cell_data(cell_data)
    );
endmodule

// File: rtl/cbus_rx_check_sva.sv
module cbus_rx_check_sva
    import cbus_rx_pkg::*;
#(
    parameter int DW    = 32,
    parameter int WORDS = 14,
    parameter int IW    = $clog2(WORDS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_start,
    input logic [DW-1:0] bus_data,
    input logic          in_cell,
    input logic          in_first,
    input logic          in_grant,
    input logic [IW-1:0] widx,
    input rx_state_e     state,
    input logic          bip_err,
    input logic          gnt_par_err,
    input logic          granted_next
);
    assert_phase_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_cell && in_grant));

    assert_start_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (in_first || frame_start));

    assert_last_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cell && widx == IW'(WORDS - 1)) |=> (in_grant || frame_start));

    assert_grant_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_grant |=> (state == ST_REQ || frame_start));

    assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_grant) |-> $stable({bip_err, gnt_par_err, granted_next}));

    assert_grant_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        granted_next |-> !gnt_par_err);

    assert_no_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_grant && !bus_data[5]) |=> !granted_next);
endmodule

bind cbus_rx_check cbus_rx_check_sva #(.DW(DW), .WORDS(WORDS), .IW(IW)) u_sva (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bus_data(bus_data),
    .in_cell(in_cell), .in_first(in_first), .in_grant(in_grant), .widx(widx),
    .state(state), .bip_err(bip_err), .gnt_par_err(gnt_par_err),
    .granted_next(granted_next)
);

// File: tb/test_cbus_rx_check.sv
`timescale 1ns/1ps
module test_cbus_rx_check;
    localparam int NW = 14;
    localparam logic [4:0] MY_UA = 5'd19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic [31:0]   bus_data = '0;
    logic [4:0]    unit_addr = MY_UA;
    logic [NW*32-1:0] cell_data;
    logic          bip_err, gnt_par_err, granted_next;

    int checks = 0;
    int failures = 0;
    logic [31:0] cw [NW];

    always #5 clk = ~clk;

    cbus_rx_check i_cbus_rx_check (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .bus_data(bus_data), .unit_addr(unit_addr), .cell_data(cell_data),
        .bip_err(bip_err), .gnt_par_err(gnt_par_err),
        .granted_next(granted_next)
    );

    task automatic chk(input string req, input logic [NW*32-1:0] act,
                       input logic [NW*32-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void fill(input int seed);
        for (int i = 0; i < NW; i++)
            cw[i] = 32'h9E37_79B9 * (seed + i + 1) ^ (32'h0101_0101 << (i % 8));
    endfunction

    function automatic logic [7:0] ref_bip();
        logic [7:0] b = 8'hFF ^ cw[0][15:8] ^ cw[0][7:0];
        for (int i = 1; i < NW; i++)
            b = b ^ cw[i][31:24] ^ cw[i][23:16] ^ cw[i][15:8] ^ cw[i][7:0];
        return b;
    endfunction

    function automatic logic [NW*32-1:0] ref_cell();
        logic [NW*32-1:0] c = '0;
        for (int i = 0; i < NW; i++) c[(NW-1-i)*32 +: 32] = cw[i];
        return c;
    endfunction

    // grant word: parity byte, enable, address, parity chosen good or bad
    function automatic logic [31:0] gword(input logic [7:0] b, input logic en,
                                          input logic [4:0] a, input logic good);
        logic p = ~(^{en, a});
        if (!good) p = ~p;
        return {b, 17'h0, p, en, a};
    endfunction

    // drive one full frame: cycle 0, 14 cell words, grant; then sit at next negedge
    task automatic frame(input logic use_start, input logic [31:0] gw);
        @(negedge clk); frame_start = use_start; bus_data = 32'hAAAA_0000;
        for (int i = 0; i < NW; i++) begin
            @(negedge clk); frame_start = 1'b0; bus_data = cw[i];
        end
        @(negedge clk); bus_data = gw;
        @(negedge clk); bus_data = 32'h0;
    endtask

    task automatic chk_flags(input string req, input logic eb, input logic ep,
                             input logic eg);
        chk({req, " bip_err"}, NW*32'(bip_err), NW*32'(eb));
        chk({req, " gnt_par_err"}, NW*32'(gnt_par_err), NW*32'(ep));
        chk({req, " granted_next"}, NW*32'(granted_next), NW*32'(eg));
    endtask

    task automatic t_reset();
        chk_flags("R10 reset", 0, 0, 0);
        chk("R10 reset cell", cell_data, '0);
        // unaligned traffic, including a valid grant to us, must be ignored
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); bus_data = gword(8'h00, 1'b1, MY_UA, 1'b1);
        end
        @(negedge clk); bus_data = '0;
        chk_flags("R10 idle", 0, 0, 0);
        chk("R10 idle cell", cell_data, '0);
    endtask

    task automatic t_good();
        fill(1);
        frame(1'b1, gword(ref_bip(), 1'b1, MY_UA, 1'b1));
        chk_flags("R3 R6 good frame", 0, 0, 1);
        chk("R2 R1 cell", cell_data, ref_cell());
    endtask

    task automatic t_hold();
        logic [NW*32-1:0] prev = cell_data;
        fill(2);
        @(negedge clk); frame_start = 1'b1; bus_data = '0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); frame_start = 1'b0; bus_data = cw[i];
        end
        chk_flags("R7 hold mid-frame", 0, 0, 1);
        chk("R2 hold cell", cell_data, prev);
        for (int i = 8; i < NW; i++) begin
            @(negedge clk); bus_data = cw[i];
        end
        @(negedge clk); bus_data = gword(ref_bip(), 1'b1, 5'd3, 1'b1);
        chk_flags("R7 before edge", 0, 0, 1);
        @(negedge clk); bus_data = '0;
        chk_flags("R6 other address", 0, 0, 0);
        chk("R2 new cell", cell_data, ref_cell());
    endtask

    task automatic t_bip_bad();
        logic [7:0] b;
        fill(3); b = ref_bip();
        cw[7] = cw[7] ^ 32'h0000_1000;
        frame(1'b1, gword(b, 1'b1, MY_UA, 1'b1));
        chk_flags("R3 corrupt payload, grant kept", 1, 0, 1);
    endtask

    task automatic t_hdr_excl();
        logic [7:0] b;
        fill(4); b = ref_bip();
        cw[0] = cw[0] ^ 32'hFFFF_0000;
        frame(1'b1, gword(b, 1'b0, MY_UA, 1'b1));
        chk_flags("R4 header bytes excluded R11", 0, 0, 0);
    endtask

    task automatic t_both_bad();
        logic [7:0] b;
        fill(5); b = ref_bip() ^ 8'h40;
        frame(1'b1, gword(b, 1'b1, MY_UA, 1'b0));
        chk_flags("R5 R3 both errors", 1, 1, 0);
        fill(6);
        frame(1'b1, gword(ref_bip(), 1'b1, MY_UA, 1'b0));
        chk_flags("R5 parity only", 0, 1, 0);
    endtask

    task automatic t_abort();
        fill(7);
        frame(1'b1, gword(ref_bip(), 1'b1, MY_UA, 1'b1));
        chk_flags("R6 setup", 0, 0, 1);
        @(negedge clk); frame_start = 1'b1; bus_data = '0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); frame_start = 1'b0; bus_data = 32'hDEAD_0000 + i;
        end
        chk_flags("R8 aborted no update", 0, 0, 1);
        fill(8);
        frame(1'b1, gword(ref_bip(), 1'b0, MY_UA, 1'b0));
        chk_flags("R8 restart result", 0, 1, 0);
        chk("R8 restart cell", cell_data, ref_cell());
    endtask

    task automatic t_freerun();
        fill(9);
        frame(1'b1, gword(ref_bip() ^ 8'h01, 1'b1, 5'd2, 1'b1));
        chk_flags("R9 first frame", 1, 0, 0);
        // the frame task already consumed the cycle-0 slot at its final negedge
        fill(10);
        for (int i = 0; i < NW; i++) begin
            @(negedge clk); bus_data = cw[i];
        end
        @(negedge clk); bus_data = gword(ref_bip(), 1'b1, MY_UA, 1'b1);
        @(negedge clk); bus_data = '0;
        chk_flags("R9 free-running frame", 0, 0, 1);
        chk("R9 free-running cell", cell_data, ref_cell());
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_good();
        t_hold();
        t_bip_bad();
        t_hdr_excl();
        t_both_bad();
        t_abort();
        t_freerun();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule